// File: doc/BRIEF.md
# AGC Update Synchronization Controller

This block decides when an automatic-gain-control stage restarts its decimated averaging cycle and when it emits a fresh update sample. It holds a small control register (immediate-sync command, initialize-on-sync, repeat-ignore and bypass) and a hold-off count register, both written through simple write strobes. It also watches an external sync pin. A rising level on the pin starts a retriggerable countdown. When the countdown expires, the block issues a restart. A software immediate sync skips the countdown and issues a restart at once.

Each restart raises a one-cycle update strobe. When initialize-on-sync is set, the same restart also raises a decimator clear pulse and a parameter-load strobe. A zero hold-off value turns every kind of synchronization off. The repeat-ignore mode honours only the first pin sync until the mode is turned off again. The bypass bit is presented directly as a select for the downstream data path.

Top module: `agc_sync_ctrl`

## Requirements
- R1: After synchronous reset, update_strobe, cic_clear and param_load are low, bypass_sel is low, the hold-off value is 0 and no countdown is pending.
- R2: The sync pin is resynchronized through two flops and only its rising level counts, so a level held high is one event. With hold-off value N (non-zero), a pin that is first sampled high at clock edge A gives update_strobe high for exactly one cycle, starting at edge A+N+2.
- R3: A new accepted pin rise during a countdown reloads the counter with the current hold-off value, so only the last rise produces an update.
- R4: While the hold-off register is 0, neither pin rises nor immediate syncs produce any strobe, and pin rises are not accepted.
- R5: A control write with bit 3 (immediate sync) set gives update_strobe for exactly one cycle, starting at the edge after the write edge. The bit clears itself, so repeating the same write repeats the update.
- R6: On each restart, cic_clear and param_load pulse together with update_strobe when control bit 2 (initialize) is 1 in the cycle before the pulse. They stay low when that bit is 0.
- R7: With control bit 1 (repeat-ignore) set, only the first accepted pin rise is honoured. Later rises are ignored while the bit stays set.
- R8: Writing control bit 1 as 0 releases the lock-out, and the next pin rise is accepted again.
- R9: bypass_sel equals control bit 0 from the edge after the write onward.
- R10: If an immediate sync and a countdown expiry fall in the same cycle, exactly one single-cycle update is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data: bit3 immediate sync, bit2 initialize, bit1 repeat-ignore, bit0 bypass |
| hold_we | input | 1 | Hold-off register write strobe |
| hold_wdata | input | 16 | Hold-off count in clock cycles, 0 disables synchronization |
| sync_pin | input | 1 | Asynchronous external sync pin |
| cic_clear | output | 1 | One-cycle decimator clear pulse |
| param_load | output | 1 | One-cycle parameter latch strobe |
| update_strobe | output | 1 | One-cycle update-sample strobe |
| bypass_sel | output | 1 | Gain-stage bypass select |

## Verification
Two things can fall in the same cycle: an immediate sync and the expiry of a pin-started countdown. The bench provokes this by raising the pin with a small hold-off value and then timing the immediate-sync write so that it lands on the expiry cycle. It then counts the update pulses over the window and requires exactly one. Constrained random pin toggles and register writes are also run against a cycle model. That model produces many other near-coincidences, such as a retrigger on the expiry cycle and a write on the accept cycle.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;

    localparam int CTL_W      = 4;
    localparam int BIT_BYPASS = 0;
    localparam int BIT_IGNORE = 1;
    localparam int BIT_INIT   = 2;
    localparam int BIT_NOW    = 3;

    // persistent control fields (the immediate-sync bit is not stored)
    typedef struct packed {
        logic init_on_sync;
        logic ignore_repeat;
        logic bypass;
    } agc_ctl_t;

    function automatic agc_ctl_t ctl_decode(input logic [CTL_W-1:0] w);
        agc_ctl_t c;
        c.init_on_sync  = w[BIT_INIT];
        c.ignore_repeat = w[BIT_IGNORE];
        c.bypass        = w[BIT_BYPASS];
        return c;
    endfunction

    function automatic logic ctl_now(input logic [CTL_W-1:0] w);
        return w[BIT_NOW];
    endfunction

endpackage

// File: rtl/agc_pin_edge.sv
module agc_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
    end

    generate
        for (genvar i = 1; i <= LAST; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign rise = chain[LAST-1] & ~chain[LAST];

    // R2: a detected rise is a single-cycle event
    a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/agc_pin_gate.sv
module agc_pin_gate (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic enable,
    input  logic ignore_repeat,
    output logic accept
);
    logic locked;

    assign accept = rise && enable && !(ignore_repeat && locked);

    always_ff @(posedge clk) begin
        if (rst)                 locked <= 1'b0;
        else if (!ignore_repeat) locked <= 1'b0;
        else if (accept)         locked <= 1'b1;
    end

    // R8: lock-out is released whenever repeat-ignore is off
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        !ignore_repeat |=> !locked);
    // R7: once a pin sync is taken in repeat-ignore mode, the gate is locked
    a_r7_lock_after_accept: assert property (@(posedge clk) disable iff (rst)
        (accept && ignore_repeat) |=> locked);
endmodule

// File: rtl/agc_holdoff_timer.sv
module agc_holdoff_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expire
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    logic [HOLD_W-1:0] cnt;
    logic              busy;

    assign expire = busy && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            cnt  <= load_val;
            busy <= (load_val != '0);
        end else if (busy) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) busy <= 1'b0;
        end
    end

    // R3: a load (re)starts the count from the supplied value
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
    // R2: expiry ends the countdown unless a new load arrives
    a_r2_expire_ends: assert property (@(posedge clk) disable iff (rst)
        (expire && !load) |=> !busy);
endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl
    import agc_sync_pkg::*;
#(
    parameter int HOLD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              hold_we,
    input  logic [HOLD_W-1:0] hold_wdata,
    input  logic              sync_pin,
    output logic              cic_clear,
    output logic              param_load,
    output logic              update_strobe,
    output logic              bypass_sel
);
    agc_ctl_t          ctl_q;
    logic [HOLD_W-1:0] hold_q;
    logic              now_q;
    logic              pin_rise;
    logic              pin_accept;
    logic              hold_expire;
    logic              sync_enabled;
    logic              restart;

    assign sync_enabled = (hold_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            hold_q <= '0;
            now_q  <= 1'b0;
        end else begin
            now_q <= ctl_we && ctl_now(ctl_wdata);
            if (ctl_we)  ctl_q  <= ctl_decode(ctl_wdata);
            if (hold_we) hold_q <= hold_wdata;
        end
    end

    agc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (sync_pin),
        .rise (pin_rise)
    );

    agc_pin_gate u_gate (
        .clk           (clk),
        .rst           (rst),
        .rise          (pin_rise),
        .enable        (sync_enabled),
        .ignore_repeat (ctl_q.ignore_repeat),
        .accept        (pin_accept)
    );

    agc_holdoff_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (pin_accept),
        .load_val (hold_q),
        .expire   (hold_expire)
    );

    // both sync paths merge into one restart event
    assign restart = (now_q || hold_expire) && sync_enabled;

    always_ff @(posedge clk) begin
        if (rst) begin
            update_strobe <= 1'b0;
            cic_clear     <= 1'b0;
            param_load    <= 1'b0;
        end else begin
            update_strobe <= restart;
            cic_clear     <= restart && ctl_q.init_on_sync;
            param_load    <= restart && ctl_q.init_on_sync;
        end
    end

    assign bypass_sel = ctl_q.bypass;

    // R4: a zero hold-off value silences every strobe
    a_r4_zero_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        !sync_enabled |=> !update_strobe);
    // R5: an immediate sync with synchronization enabled yields an update
    a_r5_now_fires: assert property (@(posedge clk) disable iff (rst)
        (now_q && sync_enabled) |=> update_strobe);
    // R6: clear and load only follow a restart taken with initialize set
    a_r6_clear_needs_init: assert property (@(posedge clk) disable iff (rst)
        (update_strobe && !$past(ctl_q.init_on_sync)) |-> (!cic_clear && !param_load));
    // R9: bypass select follows the last written bypass bit
    a_r9_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (bypass_sel == $past(ctl_wdata[BIT_BYPASS])));
endmodule

// File: tb/agc_sync_ctrl_test.sv
module agc_sync_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [3:0]  ctl_wdata;
    logic        hold_we;
    logic [15:0] hold_wdata;
    logic        sync_pin;
    logic        cic_clear, param_load, update_strobe, bypass_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R2";

    // bench model state
    bit m_s1, m_s2, m_s3, m_lock, m_busy, m_now, m_init, m_ign, m_byp;
    int m_cnt, m_hold;
    bit e_upd, e_clr, e_byp;
    int pulses;

    always #10 clk = ~clk;

    agc_sync_ctrl uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .hold_we(hold_we), .hold_wdata(hold_wdata), .sync_pin(sync_pin),
        .cic_clear(cic_clear), .param_load(param_load),
        .update_strobe(update_strobe), .bypass_sel(bypass_sel)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_s1, m_s2, m_s3, m_lock, m_busy, m_now, m_init, m_ign, m_byp} = '0;
        m_cnt = 0; m_hold = 0;
    endtask

    // one clock: drive, predict, compare after the edge
    task automatic step(input bit pin, input bit cwe, input bit [3:0] cd,
                        input bit hwe, input int hd);
        bit restart, rise, acc;
        sync_pin = pin; ctl_we = cwe; ctl_wdata = cd;
        hold_we = hwe; hold_wdata = 16'(hd);
        restart = (m_now || (m_busy && m_cnt == 1)) && m_hold != 0;
        e_upd = restart;
        e_clr = restart && m_init;
        rise = m_s2 && !m_s3;
        acc = rise && m_hold != 0 && !(m_ign && m_lock);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        if (acc) begin m_cnt = m_hold; m_busy = 1'b1; end
        else if (m_busy) begin m_cnt--; if (m_cnt == 0) m_busy = 1'b0; end
        if (!m_ign) m_lock = 1'b0; else if (acc) m_lock = 1'b1;
        m_now = cwe && cd[3];
        if (cwe) begin m_init = cd[2]; m_ign = cd[1]; m_byp = cd[0]; end
        if (hwe) m_hold = hd;
        e_byp = m_byp;
        @(posedge clk);
        @(negedge clk);
        check(cur_req, "update_strobe", update_strobe, e_upd);
        check("R6", "cic_clear", cic_clear, e_clr);
        check("R6", "param_load", param_load, e_clr);
        check("R9", "bypass_sel", bypass_sel, e_byp);
        if (update_strobe) pulses++;
    endtask

    task automatic idle(input int n, input bit pin);
        for (int i = 0; i < n; i++) step(pin, 1'b0, 4'h0, 1'b0, 0);
    endtask

    task automatic wctl(input bit [3:0] d);
        step(1'b0, 1'b1, d, 1'b0, 0);
    endtask

    task automatic whold(input int d);
        step(1'b0, 1'b0, 4'h0, 1'b1, d);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit p;
        void'($urandom(32'd4242));
        rst = 1'b1; sync_pin = 0; ctl_we = 0; ctl_wdata = 0; hold_we = 0; hold_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "update_strobe", update_strobe, 1'b0);
        check("R1", "cic_clear", cic_clear, 1'b0);
        check("R1", "param_load", param_load, 1'b0);
        check("R1", "bypass_sel", bypass_sel, 1'b0);

        // R4 before any hold-off write, syncs are dead
        cur_req = "R4";
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(2, 1'b0);
        pulses = 0; wctl(4'b1100); idle(4, 1'b0);
        check("R4", "pulses with zero hold", pulses != 0, 1'b0);

        // R2 basic countdown, N=5
        cur_req = "R2";
        whold(5);
        pulses = 0; step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(10, 1'b0);
        check("R2", "one pulse per pin rise", pulses == 1, 1'b1);
        // held-high level counts once
        pulses = 0; idle(30, 1'b1); idle(10, 1'b0);
        check("R2", "held level single pulse", pulses == 1, 1'b1);

        // R3 retrigger
        cur_req = "R3";
        pulses = 0; step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(2, 1'b0);
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(12, 1'b0);
        check("R3", "retrigger single pulse", pulses == 1, 1'b1);

        // R5 immediate sync, repeated without clearing
        cur_req = "R5";
        pulses = 0; wctl(4'b1000); idle(2, 1'b0); wctl(4'b1000); idle(2, 1'b0);
        check("R5", "two self-clearing syncs", pulses == 2, 1'b1);

        // R6 initialize on sync
        cur_req = "R6";
        wctl(4'b1100); idle(3, 1'b0);
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(10, 1'b0);

        // R4 hold zero with pin and sync-now
        cur_req = "R4";
        whold(0); pulses = 0;
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(3, 1'b0); wctl(4'b1100); idle(8, 1'b0);
        check("R4", "silent when disabled", pulses == 0, 1'b1);

        // R7 repeat-ignore
        cur_req = "R7";
        whold(3); wctl(4'b0010); pulses = 0;
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(8, 1'b0);
        end
        check("R7", "only first pin sync", pulses == 1, 1'b1);

        // R8 release
        cur_req = "R8";
        wctl(4'b0000); pulses = 0;
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(8, 1'b0);
        check("R8", "accepted after release", pulses == 1, 1'b1);

        // R9 bypass
        cur_req = "R9";
        wctl(4'b0001); idle(2, 1'b0); wctl(4'b0000); idle(2, 1'b0);

        // R10 coincidence: N=4, pin at edge A, immediate sync written at edge A+5
        cur_req = "R10";
        whold(4); pulses = 0;
        step(1'b1, 1'b0, 4'h0, 1'b0, 0); idle(4, 1'b0);
        wctl(4'b1000); idle(8, 1'b0);
        check("R10", "merged single pulse", pulses == 1, 1'b1);

        // constrained random run
        cur_req = "R2";
        p = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            bit cwe, hwe;
            if ($urandom_range(3, 0) == 0) p = ~p;
            cwe = ($urandom_range(19, 0) == 0);
            hwe = ($urandom_range(39, 0) == 0);
            step(p, cwe, 4'($urandom_range(15, 0)), hwe, int'($urandom_range(6, 0)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule